// File: doc/BRIEF.md
# TDM Slot Transmit Serializer

This block takes audio samples that a DMA engine or a processor pushes into a 32-entry sample queue and sends them one bit at a time on a serial data line. A frame is split into slots: one sample fills each active slot, and the number of active slots per frame is programmable. The frame sync generator provides the frame timing. It sends one-cycle strobes for the rising and falling bit-clock edges, plus a frame-start flag that marks the first bit of a frame.

Word length and slot length are set separately. A shorter word is placed inside a longer slot as left- or right-justified, and a longer word is cut down to fit the slot. The queue raises a service request whenever it has room for another burst. The burst size is either half or a quarter of its depth. If the queue is empty when a slot begins, the slot is sent as zeros and a sticky underrun flag is set.

Top module: `tdm_tx_serializer`

## Requirements
- R1: Reset (rst_n low at a clock edge) clears the queue and sets sdata to 0, underrun to 0, push_ready to 1 and fifo_req to 1.
- R2: The queue holds 32 samples and sends them in first-in first-out order. push_ready is 1 exactly when fewer than 32 samples are stored. A push made while push_ready is 0 is dropped.
- R3: When cfg_thresh_qtr is 0, fifo_req is 1 while at least 16 entries are free. When it is 1, fifo_req is 1 while at least 8 entries are free.
- R4: cfg_word_len selects the word length: 0=8, 1=16, 2=20, 3=24, and 4 to 7 all mean 32 bits. cfg_slot_len selects the slot length: 0=8, 1=16, and 2 or 3 mean 32 bits. The word is taken from the low bits of push_data, and each slot is sent MSB first.
- R5: cfg_left_just=1 sends the word's bits from its MSB down and pads the end of the slot with zeros. If the word is longer than the slot, its low bits are dropped. cfg_left_just=0 sends leading zeros and then the word, so the word's LSB is the last bit of the slot. If the word is longer than the slot, its high bits are dropped.
- R6: Slots 0 to cfg_slot_num-1 each take one sample (supported counts are 1, 2, 4, 6 and 8). Every bit position after the last active slot, up to the next frame start, sends 0.
- R7: When cfg_clk_pol is 0, the bit position advances only on bclk_rise. When it is 1, it advances only on bclk_fall. sdata changes one clock after the selected strobe and holds at all other times.
- R8: tx_enable is sampled on the frame-start bit. A frame that starts with tx_enable at 0 sends all zeros and takes nothing from the queue. Clearing tx_enable in the middle of a frame lets that frame finish.
- R9: If the queue is empty when an active slot begins, the slot sends zeros and underrun goes to 1 and stays there until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk_rise | input | 1 | One-cycle strobe for a rising bit-clock edge |
| bclk_fall | input | 1 | One-cycle strobe for a falling bit-clock edge |
| frame_sync | input | 1 | Marks the selected strobe as the first bit of a frame |
| cfg_word_len | input | 3 | Word length code |
| cfg_slot_len | input | 2 | Slot length code |
| cfg_slot_num | input | 4 | Active slots per frame |
| cfg_left_just | input | 1 | 1 = left-justified, 0 = right-justified |
| cfg_thresh_qtr | input | 1 | 0 = half-depth request threshold, 1 = quarter-depth threshold |
| cfg_clk_pol | input | 1 | Selects the strobe that advances the data |
| tx_enable | input | 1 | Transmit enable, sampled at frame start |
| push_valid | input | 1 | Sample write request |
| push_data | input | 32 | Sample, with the word in the low bits |
| push_ready | output | 1 | Queue can accept a sample |
| fifo_req | output | 1 | Service request for another burst |
| sdata | output | 1 | Serial data output |
| underrun | output | 1 | Sticky underrun flag |

## Verification
A push and a slot-start pop can fall in the same clock. The bench provokes this by pushing on randomly chosen bit strobes, so some pushes land on the strobe that opens a slot. Three cases are covered: a push into a full queue, which is refused even though the pop frees an entry in that same clock; a push into an empty queue, which still gives an underrun slot; and a push at a mid level, where the count stays the same. Each case is judged by comparing the serial bits of later frames, the underrun flag and push_ready against a reference queue in the bench. In that reference, the pop is taken before the push is added.

// File: rtl/tdm_tx_pkg.sv
// Shared decoding for the transmit serializer.
// Assumes the sample width is 32 bits; codes outside the listed set saturate to 32.
package tdm_tx_pkg;
    localparam int DATA_W = 32;
    localparam int LEN_W  = 6;

    // Map the word length code to a bit count.
    function automatic logic [LEN_W-1:0] word_bits(input logic [2:0] code);
        case (code)
            3'd0:    return 6'd8;
            3'd1:    return 6'd16;
            3'd2:    return 6'd20;
            3'd3:    return 6'd24;
            default: return 6'd32;
        endcase
    endfunction

    // Map the slot length code to a bit count.
    function automatic logic [LEN_W-1:0] slot_bits(input logic [1:0] code);
        case (code)
            2'd0:    return 6'd8;
            2'd1:    return 6'd16;
            default: return 6'd32;
        endcase
    endfunction
endpackage

// File: rtl/tdm_tx_fifo.sv
// Sample queue with a read port that shows the head entry.
// Assumes DEPTH is a power of two. The caller never pushes when full and never pops when empty.
module tdm_tx_fifo #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              empty
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;

    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);
    assign head  = mem[rd_ptr];

    // Write storage on an accepted push.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    // Move the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH)); // R2
    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R9
    AST_FULL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> full); // R2
endmodule

// File: rtl/tdm_tx_format.sv
// Places a word inside a slot and returns the slot bits aligned to the MSB, so they can be shifted out MSB first.
// Purely combinational. Lengths come from the package decoders.
module tdm_tx_format
    import tdm_tx_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    input  logic [2:0]        word_code,
    input  logic [1:0]        slot_code,
    input  logic              left_just,
    output logic [DATA_W-1:0] slot_vec
);
    logic [LEN_W-1:0]  wl;
    logic [LEN_W-1:0]  sl;
    logic [DATA_W-1:0] masked;

    // Keep only the word bits, then align for the selected justification.
    always_comb begin
        wl = word_bits(word_code);
        sl = slot_bits(slot_code);
        if (wl >= LEN_W'(DATA_W)) masked = data;
        else                      masked = data & ((DATA_W'(1) << wl) - 1'b1);
        if (left_just) slot_vec = masked << (LEN_W'(DATA_W) - wl);
        else           slot_vec = masked << (LEN_W'(DATA_W) - sl);
    end
endmodule

// File: rtl/tdm_tx_shifter.sv
// Frame and slot sequencer with an output shift register.
// Assumes the tick input is a one-cycle strobe and that slot_vec shows the queue head in the same cycle.
module tdm_tx_shifter
    import tdm_tx_pkg::*;
#(
    parameter int MAX_SLOTS = 15,
    localparam int SLOT_W   = $clog2(MAX_SLOTS + 1),
    localparam int BIT_W    = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              frame_start,
    input  logic              tx_enable,
    input  logic [1:0]        slot_code,
    input  logic [SLOT_W-1:0] slot_num,
    input  logic [DATA_W-1:0] slot_vec,
    input  logic              fifo_empty,
    output logic              pop,
    output logic              sdata,
    output logic              underrun
);
    logic [BIT_W-1:0]  bit_cnt, nxt_bit;
    logic [SLOT_W-1:0] slot_cnt, nxt_slot;
    logic              run, nxt_run;
    logic              act, load;
    logic [DATA_W-1:0] shreg;
    logic [LEN_W-1:0]  sl;

    // Work out the frame position that the current tick moves to.
    always_comb begin
        sl       = slot_bits(slot_code);
        nxt_run  = run;
        nxt_bit  = bit_cnt + 1'b1;
        nxt_slot = slot_cnt;
        if (frame_start) begin
            nxt_run  = tx_enable;
            nxt_bit  = '0;
            nxt_slot = '0;
        end else if ({1'b0, bit_cnt} == sl - 1'b1) begin
            nxt_bit = '0;
            if (slot_cnt != SLOT_W'(MAX_SLOTS)) nxt_slot = slot_cnt + 1'b1;
        end
        act  = nxt_run && (nxt_slot < slot_num);
        load = tick && act && (nxt_bit == '0);
        pop  = load && !fifo_empty;
    end

    // Update position and output bit on each selected bit-clock tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            slot_cnt <= '0;
            run      <= 1'b0;
            shreg    <= '0;
            sdata    <= 1'b0;
            underrun <= 1'b0;
        end else if (tick) begin
            bit_cnt  <= nxt_bit;
            slot_cnt <= nxt_slot;
            run      <= nxt_run;
            if (load && fifo_empty) begin
                shreg    <= '0;
                sdata    <= 1'b0;
                underrun <= 1'b1;
            end else if (load) begin
                shreg <= slot_vec << 1;
                sdata <= slot_vec[DATA_W-1];
            end else if (act) begin
                shreg <= shreg << 1;
                sdata <= shreg[DATA_W-1];
            end else begin
                sdata <= 1'b0;
            end
        end
    end

    AST_SDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(sdata)); // R7
    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun); // R9
    AST_IDLE_FRAME_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && frame_start && !tx_enable) |=> !sdata); // R8
    AST_EMPTY_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (load && fifo_empty) |=> (!sdata && underrun)); // R9
endmodule

// File: rtl/tdm_tx_serializer.sv
// TDM slot transmit serializer: a sample queue, word-in-slot formatting and a serial shifter.
// Assumes the bit-clock strobes come from the frame sync generator and last one clock each.
module tdm_tx_serializer
    import tdm_tx_pkg::*;
#(
    parameter int DEPTH     = 32,
    parameter int MAX_SLOTS = 15,
    localparam int CNT_W    = $clog2(DEPTH + 1),
    localparam int SLOT_W   = $clog2(MAX_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_rise,
    input  logic              bclk_fall,
    input  logic              frame_sync,
    input  logic [2:0]        cfg_word_len,
    input  logic [1:0]        cfg_slot_len,
    input  logic [SLOT_W-1:0] cfg_slot_num,
    input  logic              cfg_left_just,
    input  logic              cfg_thresh_qtr,
    input  logic              cfg_clk_pol,
    input  logic              tx_enable,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    output logic              push_ready,
    output logic              fifo_req,
    output logic              sdata,
    output logic              underrun
);
    logic              tick;
    logic              push, pop, full, empty;
    logic [CNT_W-1:0]  count;
    logic [CNT_W-1:0]  free_cnt;
    logic [DATA_W-1:0] head, slot_vec;

    // Pick the launching strobe and derive the queue-side controls.
    always_comb begin
        tick       = cfg_clk_pol ? bclk_fall : bclk_rise;
        push_ready = !full;
        push       = push_valid && !full;
        free_cnt   = CNT_W'(DEPTH) - count;
        fifo_req   = cfg_thresh_qtr ? (free_cnt >= CNT_W'(DEPTH / 4))
                                    : (free_cnt >= CNT_W'(DEPTH / 2));
    end

    tdm_tx_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) fifo_i (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
        .pop(pop), .head(head), .count(count), .full(full), .empty(empty)
    );

    tdm_tx_format fmt_i (
        .data(head), .word_code(cfg_word_len), .slot_code(cfg_slot_len),
        .left_just(cfg_left_just), .slot_vec(slot_vec)
    );

    tdm_tx_shifter #(.MAX_SLOTS(MAX_SLOTS)) shf_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .frame_start(frame_sync && tick),
        .tx_enable(tx_enable), .slot_code(cfg_slot_len), .slot_num(cfg_slot_num),
        .slot_vec(slot_vec), .fifo_empty(empty), .pop(pop),
        .sdata(sdata), .underrun(underrun)
    );

    AST_REFUSE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !push_ready && !pop) |=> $stable(push_ready)); // R2
    AST_REQ_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> fifo_req); // R3
endmodule

// File: tb/tdm_tx_serializer_tb.sv
module tdm_tx_serializer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk_rise = 1'b0, bclk_fall = 1'b0, frame_sync = 1'b0;
    logic [2:0]  cfg_word_len = 3'd1;
    logic [1:0]  cfg_slot_len = 2'd1;
    logic [3:0]  cfg_slot_num = 4'd2;
    logic        cfg_left_just = 1'b1, cfg_thresh_qtr = 1'b0, cfg_clk_pol = 1'b0;
    logic        tx_enable = 1'b0, push_valid = 1'b0;
    logic [31:0] push_data = '0;
    logic        push_ready, fifo_req, sdata, underrun;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] mq [$];
    bit m_under = 0;

    always #4 clk = ~clk;

    tdm_tx_serializer dut_i (
        .clk(clk), .rst_n(rst_n), .bclk_rise(bclk_rise), .bclk_fall(bclk_fall),
        .frame_sync(frame_sync), .cfg_word_len(cfg_word_len), .cfg_slot_len(cfg_slot_len),
        .cfg_slot_num(cfg_slot_num), .cfg_left_just(cfg_left_just),
        .cfg_thresh_qtr(cfg_thresh_qtr), .cfg_clk_pol(cfg_clk_pol), .tx_enable(tx_enable),
        .push_valid(push_valid), .push_data(push_data), .push_ready(push_ready),
        .fifo_req(fifo_req), .sdata(sdata), .underrun(underrun)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int wl_of(input logic [2:0] c);
        return (c == 0) ? 8 : (c == 1) ? 16 : (c == 2) ? 20 : (c == 3) ? 24 : 32;
    endfunction

    function automatic int sl_of(input logic [1:0] c);
        return (c == 0) ? 8 : (c == 1) ? 16 : 32;
    endfunction

    function automatic logic exp_bit(input logic [31:0] d, input int wl, input int sl, input bit lj, input int pos);
        int idx;
        if (lj) idx = wl - 1 - pos;
        else begin
            idx = sl - 1 - pos;
            if (idx >= wl) return 1'b0;
        end
        if (idx < 0) return 1'b0;
        return d[idx];
    endfunction

    function automatic logic exp_req();
        int free_n = 32 - mq.size();
        return cfg_thresh_qtr ? (free_n >= 8) : (free_n >= 16);
    endfunction

    task automatic push_only(input logic [31:0] d);
        @(negedge clk);
        push_valid = 1'b1;
        push_data  = d;
        chk(push_ready == (mq.size() < 32), "R2 push_ready", push_ready, mq.size() < 32);
        @(negedge clk);
        push_valid = 1'b0;
        if (mq.size() < 32) mq.push_back(d);
        chk(fifo_req == exp_req(), "R3 fifo_req", fifo_req, exp_req());
    endtask

    // One frame; mid_off clears tx_enable at bit 3; push_pct is the chance of a push per bit.
    task automatic run_frame(input int pad, input int push_pct, input bit mid_off);
        int wl = wl_of(cfg_word_len);
        int sl = sl_of(cfg_slot_len);
        int nbits = int'(cfg_slot_num) * sl + pad;
        bit run = 0;
        logic [31:0] cur = '0;
        for (int b = 0; b < nbits; b++) begin
            int slot = b / sl;
            int pos = b % sl;
            bit act, acc, do_push;
            logic e;
            @(negedge clk);
            if (mid_off && b == 3) tx_enable = 1'b0;
            if (cfg_clk_pol) bclk_fall = 1'b1; else bclk_rise = 1'b1;
            frame_sync = (b == 0);
            do_push = ($urandom_range(0, 99) < push_pct);
            push_valid = do_push;
            push_data = $urandom;
            if (b == 0) run = tx_enable;
            act = run && (slot < int'(cfg_slot_num));
            acc = do_push && (mq.size() < 32);
            if (act && pos == 0) begin
                if (mq.size() == 0) begin cur = '0; m_under = 1; end
                else cur = mq.pop_front();
            end
            if (acc) mq.push_back(push_data);
            e = act ? exp_bit(cur, wl, sl, cfg_left_just, pos) : 1'b0;
            @(negedge clk);
            bclk_rise = 1'b0; bclk_fall = 1'b0; frame_sync = 1'b0; push_valid = 1'b0;
            chk(sdata == e, act ? "R4 R5 R6 slot bit" : "R6 R8 zero bit", sdata, e);
            chk(underrun == m_under, "R9 underrun", underrun, m_under);
            chk(fifo_req == exp_req(), "R3 fifo_req", fifo_req, exp_req());
            @(negedge clk);
            if (cfg_clk_pol) bclk_rise = 1'b1; else bclk_fall = 1'b1;
            frame_sync = 1'b1;
            @(negedge clk);
            bclk_rise = 1'b0; bclk_fall = 1'b0; frame_sync = 1'b0;
            chk(sdata == e, "R7 other strobe ignored", sdata, e);
        end
    endtask

    task automatic fill_to(input int lvl);
        while (mq.size() < lvl) push_only($urandom);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sdata == 1'b0, "R1 sdata", sdata, 0);
        chk(underrun == 1'b0, "R1 underrun", underrun, 0);
        chk(push_ready == 1'b1, "R1 push_ready", push_ready, 1);
        chk(fifo_req == 1'b1, "R1 fifo_req", fifo_req, 1);

        // R2 R3: fill past capacity with both threshold settings
        for (int i = 0; i < 14; i++) push_only($urandom);
        cfg_thresh_qtr = 1'b1;
        for (int i = 0; i < 20; i++) push_only($urandom);
        chk(push_ready == 1'b0, "R2 full", push_ready, 0);
        cfg_thresh_qtr = 1'b0;
        #1 chk(fifo_req == 1'b0, "R3 full no req", fifo_req, 0);

        // R8: disabled frame takes nothing
        tx_enable = 1'b0;
        run_frame(4, 0, 0);
        // R4 R5: directed format cases, full-queue push collisions
        tx_enable = 1'b1;
        cfg_word_len = 3'd1; cfg_slot_len = 2'd2; cfg_slot_num = 4'd2; cfg_left_just = 1'b1;
        run_frame(3, 50, 0);
        cfg_left_just = 1'b0;
        run_frame(2, 50, 0);
        cfg_word_len = 3'd3; cfg_slot_len = 2'd1; cfg_slot_num = 4'd4;
        run_frame(5, 30, 0);
        cfg_left_just = 1'b1;
        run_frame(0, 30, 0);
        cfg_word_len = 3'd7; cfg_slot_len = 2'd3; cfg_slot_num = 4'd1;
        run_frame(2, 0, 0);
        // R8: clear enable in mid-frame, then a disabled frame
        cfg_word_len = 3'd0; cfg_slot_len = 2'd0; cfg_slot_num = 4'd8;
        run_frame(4, 0, 1);
        run_frame(2, 0, 0);
        tx_enable = 1'b1;
        // R7: falling-strobe polarity
        cfg_clk_pol = 1'b1; cfg_word_len = 3'd2; cfg_slot_len = 2'd2; cfg_slot_num = 4'd6;
        run_frame(3, 20, 0);

        // Random frames
        for (int f = 0; f < 30; f++) begin
            int nsel = $urandom_range(0, 4);
            cfg_word_len   = 3'($urandom_range(0, 7));
            cfg_slot_len   = 2'($urandom_range(0, 3));
            cfg_slot_num   = (nsel == 0) ? 4'd1 : 4'(nsel * 2);
            cfg_left_just  = 1'($urandom_range(0, 1));
            cfg_clk_pol    = 1'($urandom_range(0, 1));
            cfg_thresh_qtr = 1'($urandom_range(0, 1));
            tx_enable      = ($urandom_range(0, 9) != 0);
            fill_to($urandom_range(0, 32));
            run_frame($urandom_range(0, 6), $urandom_range(0, 40), 0);
        end

        // R9: drain and run with an empty queue, including pushes landing at slot start
        cfg_slot_len = 2'd0; cfg_slot_num = 4'd8; tx_enable = 1'b1; cfg_clk_pol = 1'b0;
        while (mq.size() > 0) run_frame(1, 0, 0);
        run_frame(2, 30, 0);
        chk(underrun == 1'b1, "R9 sticky flag", underrun, 1);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule